// File: doc/BRIEF.md
# ADC Control Register Decoder

This block is the write-only control register in the digital core of a multi-channel sampling converter. The serial front end hands it complete 16-bit words. The top two bits of each word are a register address and the low fourteen bits are data. A word whose address bits are both 1 replaces the whole register. The register's fields then drive the analog input configuration, the power-management code, the read-path register select, the data-pin direction, and the start of conversions and calibrations.

Three bits clear themselves when the surrounding engines report back:
- The conversion-start bit clears at end of conversion.
- The calibration-start bit clears at end of calibration.
- The interface-mode bit clears at the end of every read cycle.

Each start bit also produces a single-cycle launch pulse. The two calibration-select bits are steered to one of two outputs, depending on whether a calibration is running. While one runs they name its type. Otherwise they address the coefficient bank.

Top module: `adc_ctrl_reg`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises with no other input active, all 14 register bits are 0. Every field output, busy flag and pulse is then 0, coef_addr_valid is 1 and coef_addr is 0.
- R2: A word is accepted only when wr_valid is 1 and wr_word[15:14] is 2'b11. Any other address, or wr_valid low, leaves every output unchanged, and neither pulse fires.
- R3: An accepted word replaces all 14 bits, and the result is visible one cycle after the write edge. The fields map as follows:
  - wr_word[13] to in_single_ended (1 = single-ended, 0 = pseudo-differential).
  - wr_word[12:10] to chan_sel.
  - wr_word[9:8] to pwr_code.
  - wr_word[7:6] to rd_sel.
  - wr_word[3] to cal_mode_sys (1 = system, 0 = self).
- R4: wr_word[4] is the conversion-start bit, and conv_busy follows it. When an accepted word has this bit set, conv_pulse is 1 for exactly the one cycle in which conv_busy first reflects that write.
- R5: eoc_stb clears conv_busy on the next edge and leaves every other bit unchanged.
- R6: wr_word[0] is the calibration-start bit, and cal_busy follows it. An accepted word with this bit set gives a one-cycle cal_pulse. eocal_stb clears cal_busy and leaves every other bit unchanged.
- R7: The calibration-select bits (wr_word[2:1]) are steered by cal_busy:
  - While cal_busy is 1: cal_type carries them, cal_type_valid is 1, coef_addr is 0 and coef_addr_valid is 0.
  - While cal_busy is 0: coef_addr carries them, coef_addr_valid is 1, cal_type is 0 and cal_type_valid is 0.
- R8: wr_word[5] drives din_bidir_en, where 1 means the data-in pin is bidirectional. eord_stb clears it and leaves every other bit unchanged.
- R9: When an accepted write and a clearing strobe for the same bit occur in the same cycle, the written value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | A complete serial word is present |
| wr_word | input | 16 | Address in [15:14], data in [13:0] |
| eoc_stb | input | 1 | End-of-conversion strobe |
| eocal_stb | input | 1 | End-of-calibration strobe |
| eord_stb | input | 1 | End-of-read-cycle strobe |
| in_single_ended | output | 1 | Input mode, 1 = single-ended |
| chan_sel | output | 3 | Channel code |
| pwr_code | output | 2 | Power-management code |
| rd_sel | output | 2 | Read-register select |
| din_bidir_en | output | 1 | Data-in pin acts bidirectionally |
| conv_busy | output | 1 | Conversion-start bit is set |
| conv_pulse | output | 1 | One-cycle conversion launch |
| cal_mode_sys | output | 1 | 1 = system calibration |
| cal_busy | output | 1 | Calibration-start bit is set |
| cal_pulse | output | 1 | One-cycle calibration launch |
| cal_type | output | 2 | Calibration type while calibrating |
| cal_type_valid | output | 1 | cal_type is meaningful |
| coef_addr | output | 2 | Coefficient bank address while idle |
| coef_addr_valid | output | 1 | coef_addr is meaningful |

## Verification
The assertions check several rules on every cycle:
- the exclusive steering of the calibration-select bits;
- that a pulse never appears without its busy flag;
- that each strobe clears its own bit when no write arrives;
- that writes win over strobes;
- that nothing moves when there is neither an accepted write nor a strobe.

Only the bench's scenarios show the rest:
- the exact placement of every field, through a sweep of all 16384 data values;
- that strobes leave the other bits untouched;
- that rejected addresses keep a prior non-trivial state intact.

// File: rtl/adc_ctrl_pkg.sv
// Package: shared widths, address code and field layout of the control word.
// Assumes the 14 data bits keep the fixed layout the downstream logic decodes.
package adc_ctrl_pkg;
    localparam int WORD_W    = 16;
    localparam int DATA_W    = 14;
    localparam int ADDR_W    = WORD_W - DATA_W;
    localparam int CHAN_W    = 3;
    localparam int PWR_W     = 2;
    localparam int RSEL_W    = 2;
    localparam int CSEL_W    = 2;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = '1;

    // Packed MSB-first in the same order as data bits 13..0.
    typedef struct packed {
        logic              in_se;
        logic [CHAN_W-1:0] chan;
        logic [PWR_W-1:0]  pwr;
        logic [RSEL_W-1:0] rsel;
        logic              ifm;
        logic              conv;
        logic              calsys;
        logic [CSEL_W-1:0] calsel;
        logic              calgo;
    } ctrl_fields_t;
endpackage

// File: rtl/adc_ctrl_wr_decode.sv
// Module: address match and field split of an incoming serial word.
// Assumes wr_word is stable whenever wr_valid is high; purely combinational.
module adc_ctrl_wr_decode
    import adc_ctrl_pkg::*;
(
    input  logic                wr_valid,
    input  logic [WORD_W-1:0]   wr_word,
    output logic                hit,
    output ctrl_fields_t        fields
);
    // Accept only the control-register address.
    always_comb hit = wr_valid && (wr_word[WORD_W-1:DATA_W] == CTRL_ADDR);

    // Reinterpret the data bits as named fields.
    always_comb fields = ctrl_fields_t'(wr_word[DATA_W-1:0]);
endmodule

// File: rtl/adc_ctrl_selfclr.sv
// Module: one register bit that loads on a write and clears on an event strobe.
// Assumes load and clr are synchronous to clk; load takes priority over clr.
module adc_ctrl_selfclr (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_val,
    input  logic clr,
    output logic q
);
    // Hold, load or clear the bit, with the write winning.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= 1'b0;
        else if (load) q <= load_val;
        else if (clr)  q <= 1'b0;
    end
endmodule

// File: rtl/adc_ctrl_cal_steer.sv
// Module: routes the calibration-select bits to either a calibration type or
// a coefficient address, depending on whether a calibration is running.
// Assumes calgo is the registered calibration-start bit; combinational.
module adc_ctrl_cal_steer
    import adc_ctrl_pkg::*;
(
    input  logic              calgo,
    input  logic [CSEL_W-1:0] calsel,
    output logic [CSEL_W-1:0] cal_type,
    output logic              cal_type_valid,
    output logic [CSEL_W-1:0] coef_addr,
    output logic              coef_addr_valid
);
    // Present the select bits on exactly one of the two outputs.
    always_comb begin
        cal_type_valid  = calgo;
        coef_addr_valid = !calgo;
        cal_type        = calgo ? calsel : '0;
        coef_addr       = calgo ? '0 : calsel;
    end
endmodule

// File: rtl/adc_ctrl_reg.sv
// Module: write-only control register of a sampling converter core.
// Latches accepted 14-bit words, self-clears the start and interface-mode
// bits on their end strobes, and issues one-cycle launch pulses.
// Assumes all inputs are synchronous to clk; reset is synchronous active-low.
module adc_ctrl_reg
    import adc_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              eoc_stb,
    input  logic              eocal_stb,
    input  logic              eord_stb,
    output logic              in_single_ended,
    output logic [CHAN_W-1:0] chan_sel,
    output logic [PWR_W-1:0]  pwr_code,
    output logic [RSEL_W-1:0] rd_sel,
    output logic              din_bidir_en,
    output logic              conv_busy,
    output logic              conv_pulse,
    output logic              cal_mode_sys,
    output logic              cal_busy,
    output logic              cal_pulse,
    output logic [CSEL_W-1:0] cal_type,
    output logic              cal_type_valid,
    output logic [CSEL_W-1:0] coef_addr,
    output logic              coef_addr_valid
);
    localparam int NSC = 3;     // number of self-clearing bits

    logic              hit;
    ctrl_fields_t      fields;
    logic [CSEL_W-1:0] calsel_q;
    logic [NSC-1:0]    sc_val, sc_clr, sc_q;

    adc_ctrl_wr_decode u_dec (
        .wr_valid (wr_valid),
        .wr_word  (wr_word),
        .hit      (hit),
        .fields   (fields)
    );

    // Plain fields: loaded on an accepted write, otherwise held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_single_ended <= 1'b0;
            chan_sel        <= '0;
            pwr_code        <= '0;
            rd_sel          <= '0;
            cal_mode_sys    <= 1'b0;
            calsel_q        <= '0;
        end else if (hit) begin
            in_single_ended <= fields.in_se;
            chan_sel        <= fields.chan;
            pwr_code        <= fields.pwr;
            rd_sel          <= fields.rsel;
            cal_mode_sys    <= fields.calsys;
            calsel_q        <= fields.calsel;
        end
    end

    // Pair each self-clearing bit with its clearing strobe.
    always_comb begin
        sc_val = {fields.ifm, fields.conv, fields.calgo};
        sc_clr = {eord_stb,   eoc_stb,     eocal_stb};
    end

    for (genvar i = 0; i < NSC; i++) begin : g_sc
        adc_ctrl_selfclr u_bit (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (hit),
            .load_val (sc_val[i]),
            .clr      (sc_clr[i]),
            .q        (sc_q[i])
        );
    end

    always_comb {din_bidir_en, conv_busy, cal_busy} = sc_q;

    // Launch pulses: one cycle, aligned with the busy flag first showing the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_pulse <= 1'b0;
            cal_pulse  <= 1'b0;
        end else begin
            conv_pulse <= hit && fields.conv;
            cal_pulse  <= hit && fields.calgo;
        end
    end

    adc_ctrl_cal_steer u_steer (
        .calgo           (cal_busy),
        .calsel          (calsel_q),
        .cal_type        (cal_type),
        .cal_type_valid  (cal_type_valid),
        .coef_addr       (coef_addr),
        .coef_addr_valid (coef_addr_valid)
    );
endmodule

// File: rtl/adc_ctrl_reg_chk.sv
// Module: cycle-by-cycle property checker for adc_ctrl_reg, bound below.
// Assumes it sees only the top-level ports.
module adc_ctrl_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_valid,
    input logic [15:0] wr_word,
    input logic        eoc_stb,
    input logic        eocal_stb,
    input logic        eord_stb,
    input logic        in_single_ended,
    input logic [2:0]  chan_sel,
    input logic [1:0]  pwr_code,
    input logic [1:0]  rd_sel,
    input logic        din_bidir_en,
    input logic        conv_busy,
    input logic        conv_pulse,
    input logic        cal_mode_sys,
    input logic        cal_busy,
    input logic        cal_pulse,
    input logic [1:0]  cal_type,
    input logic        cal_type_valid,
    input logic [1:0]  coef_addr,
    input logic        coef_addr_valid
);
    logic acc;
    logic quiet;

    // Independent view of an accepted write and of an event-free cycle.
    always_comb begin
        acc   = wr_valid && (wr_word[15:14] == 2'b11);
        quiet = !acc && !eoc_stb && !eocal_stb && !eord_stb;
    end

    a_r2_hold_when_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> $stable({in_single_ended, chan_sel, pwr_code, rd_sel,
                           din_bidir_en, conv_busy, cal_mode_sys, cal_busy,
                           cal_type, coef_addr}) && !conv_pulse && !cal_pulse);

    a_r4_pulse_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
        conv_pulse |-> conv_busy);

    a_r5_eoc_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_stb && !acc) |=> !conv_busy);

    a_r6_eocal_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (eocal_stb && !acc) |=> !cal_busy && (cal_pulse == 1'b0));

    a_r6_pulse_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cal_pulse |-> cal_busy);

    a_r7_steer_cal: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy |-> (cal_type_valid && !coef_addr_valid && coef_addr == 2'b00));

    a_r7_steer_coef: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_busy |-> (coef_addr_valid && !cal_type_valid && cal_type == 2'b00));

    a_r8_eord_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (eord_stb && !acc) |=> !din_bidir_en);

    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && wr_word[4] && wr_word[0] && wr_word[5]) |=>
            (conv_busy && conv_pulse && cal_busy && cal_pulse && din_bidir_en));
endmodule

bind adc_ctrl_reg adc_ctrl_reg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_word(wr_word),
    .eoc_stb(eoc_stb), .eocal_stb(eocal_stb), .eord_stb(eord_stb),
    .in_single_ended(in_single_ended), .chan_sel(chan_sel),
    .pwr_code(pwr_code), .rd_sel(rd_sel), .din_bidir_en(din_bidir_en),
    .conv_busy(conv_busy), .conv_pulse(conv_pulse),
    .cal_mode_sys(cal_mode_sys), .cal_busy(cal_busy), .cal_pulse(cal_pulse),
    .cal_type(cal_type), .cal_type_valid(cal_type_valid),
    .coef_addr(coef_addr), .coef_addr_valid(coef_addr_valid)
);

// File: tb/adc_ctrl_reg_tb.sv
`timescale 1ns/1ps
// Bench: exhaustive data sweep plus address, strobe and collision scenarios,
// compared against a bit-level model derived from the requirements.
module adc_ctrl_reg_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic [15:0] wr_word = '0;
    logic eoc_stb = 1'b0, eocal_stb = 1'b0, eord_stb = 1'b0;
    logic in_single_ended, din_bidir_en, conv_busy, conv_pulse;
    logic cal_mode_sys, cal_busy, cal_pulse, cal_type_valid, coef_addr_valid;
    logic [2:0] chan_sel;
    logic [1:0] pwr_code, rd_sel, cal_type, coef_addr;

    int n_cmp = 0;
    int n_bad = 0;

    logic [13:0] m = '0;        // model of the 14 register bits
    logic mp_conv = 1'b0;       // expected conv_pulse
    logic mp_cal  = 1'b0;       // expected cal_pulse

    always #2.5 clk = ~clk;

    adc_ctrl_reg u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_word(wr_word),
        .eoc_stb(eoc_stb), .eocal_stb(eocal_stb), .eord_stb(eord_stb),
        .in_single_ended(in_single_ended), .chan_sel(chan_sel),
        .pwr_code(pwr_code), .rd_sel(rd_sel), .din_bidir_en(din_bidir_en),
        .conv_busy(conv_busy), .conv_pulse(conv_pulse),
        .cal_mode_sys(cal_mode_sys), .cal_busy(cal_busy), .cal_pulse(cal_pulse),
        .cal_type(cal_type), .cal_type_valid(cal_type_valid),
        .coef_addr(coef_addr), .coef_addr_valid(coef_addr_valid)
    );

    function automatic logic [19:0] expected();
        return {m[13], m[12:10], m[9:8], m[7:6], m[5], m[4], mp_conv, m[3],
                m[0], mp_cal, m[0], (m[0] ? m[2:1] : 2'b00),
                !m[0], (m[0] ? 2'b00 : m[2:1])};
    endfunction

    function automatic logic [19:0] observed();
        return {in_single_ended, chan_sel, pwr_code, rd_sel, din_bidir_en,
                conv_busy, conv_pulse, cal_mode_sys, cal_busy, cal_pulse,
                cal_type_valid, cal_type, coef_addr_valid, coef_addr};
    endfunction

    task automatic check(input string req);
        n_cmp++;
        if (observed() !== expected()) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, observed(), expected());
        end
    endtask

    // Called at a negedge: drive one cycle, update the model, return at the next negedge.
    task automatic cycle(input logic v, input logic [15:0] w,
                         input logic e_conv, input logic e_cal, input logic e_rd);
        logic acc;
        wr_valid = v; wr_word = w;
        eoc_stb = e_conv; eocal_stb = e_cal; eord_stb = e_rd;
        acc = v && (w[15:14] == 2'b11);
        @(negedge clk);
        mp_conv = acc && w[4];
        mp_cal  = acc && w[0];
        if (acc) m = w[13:0];
        else begin
            if (e_conv) m[4] = 1'b0;
            if (e_cal)  m[0] = 1'b0;
            if (e_rd)   m[5] = 1'b0;
        end
        wr_valid = 1'b0; eoc_stb = 1'b0; eocal_stb = 1'b0; eord_stb = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 during reset");
        rst_n = 1'b1;
        cycle(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0);
        check("R1 after reset");

        // R3 R4 R6 R7 R8: every data value written at the control address.
        for (int d = 0; d < 16384; d++) begin
            cycle(1'b1, {2'b11, 14'(d)}, 1'b0, 1'b0, 1'b0);
            check("R3/R4/R6/R7/R8 sweep");
        end

        // R2: other addresses and wr_valid low leave a known state unchanged.
        for (int a = 0; a < 4; a++) begin
            for (int d = 0; d < 16384; d += 97) begin
                cycle(1'b1, {2'b11, 14'h2AB5}, 1'b0, 1'b0, 1'b0);
                if (a == 3) cycle(1'b0, {2'b11, 14'(d)}, 1'b0, 1'b0, 1'b0);
                else        cycle(1'b1, {2'(a), 14'(d)}, 1'b0, 1'b0, 1'b0);
                check("R2 rejected word");
            end
        end

        // R5 R6 R8: each strobe clears only its own bit.
        for (int p = 0; p < 8; p++) begin
            logic [13:0] base;
            base = 14'h0031 | 14'((p * 14'h0A46) & 14'h3FCE);
            cycle(1'b1, {2'b11, base}, 1'b0, 1'b0, 1'b0);
            cycle(1'b0, 16'h0000, 1'b1, 1'b0, 1'b0);
            check("R5 eoc clears conversion bit");
            cycle(1'b0, 16'h0000, 1'b0, 1'b0, 1'b1);
            check("R8 eord clears interface bit");
            cycle(1'b0, 16'h0000, 1'b0, 1'b1, 1'b0);
            check("R6 eocal clears calibration bit");
            check("R7 steering after calibration ends");
            cycle(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0);
            check("R2 idle hold");
        end

        // R9: a write and a clearing strobe in the same cycle.
        cycle(1'b1, {2'b11, 14'h0031}, 1'b0, 1'b0, 1'b0);
        cycle(1'b1, {2'b11, 14'h1A37}, 1'b1, 1'b1, 1'b1);
        check("R9 write beats strobes");
        cycle(1'b1, {2'b11, 14'h0000}, 1'b1, 1'b1, 1'b1);
        check("R9 write of zero with strobes");
        cycle(1'b1, {2'b01, 14'h3FFF}, 1'b1, 1'b0, 1'b0);
        check("R2 rejected word with strobe");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule